// File: doc/BRIEF.md
# Keyed write-protection controller for a byte-wide EEPROM

This block sits behind the decoded host bus of a byte-wide parallel EEPROM model and has a single clock. Every write strobe is collected into a small page buffer during a load phase. The phase closes once the bus has carried no write for a set number of cycles. At that moment the controller decides which of the buffered bytes reach the internal array, and then runs a fixed-length write cycle. While that cycle runs, reads return status instead of stored data. Bit 6 flips on every read. Bit 7 is the complement of bit 7 of the last byte loaded. This lets host software find the end of the cycle by polling.

Protection against stray writes uses a persistent flag and a three-write key. The key is AA written to 5555h, then 55 to 2AAAh, then A0 to 5555h. When the key opens a load phase, it sets the flag at the end of that write cycle, and it also unlocks the bytes that follow it in the same load. A six-write key clears the flag: AA, 55, 80, AA, 55, 20, written alternately to 5555h, 2AAAh, 5555h, 5555h, 2AAAh, 5555h. While the flag is set, a load without the key stores nothing, but it still runs the write cycle. The flag is never cleared by reset.

Top module: `eeprom_guard`

## Requirements
- R1: While rst_n is low and after it rises, busy is 0 and rd_data is 00h. A reset during a write cycle ends it at once. Reset changes neither the array nor the protection flag.
- R2: A load phase begins with the first write accepted while busy is 0. It closes after PAGE_WIN consecutive cycles without an accepted write. busy then goes to 1, PAGE_WIN cycles after the last accepted write, and stays at 1 for exactly TWC cycles. Write strobes while busy is 1 are ignored and do not start a new load.
- R3: With protection off, every byte buffered in a load is stored at array index wr_addr[ARR_W-1:0]. When two bytes target the same index, the later one wins.
- R4: A read issued while busy is 1 returns {~d7, t, 000000b}. Here d7 is bit 7 of the last byte loaded, and t is 1 on the first read of the cycle and alternates on every further read. A read while busy is 0 returns array[rd_addr] on the next cycle.
- R5: If the first three writes of a load are AA@5555h, 55@2AAAh and A0@5555h, those three bytes are not stored. Protection turns on at the end of that write cycle. Bytes after the key in the same load are stored.
- R6: With protection on, a load that starts with the R5 key stores the bytes after the key.
- R7: With protection on, a load that does not start with a complete key stores nothing. It still produces the full R2 write cycle, with status reads.
- R8: A load whose first six writes are AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh and 20@5555h stores none of them. Protection turns off at the end of that cycle, and later plain loads are stored.
- R9: Protection set by R5 survives any number of resets.
- R10: A key that is broken by a wrong byte or address, or cut short by the load closing, counts as an ordinary load. Its bytes are stored when protection is off and dropped when it is on.
- R11: Writes after the PAGE_SZ-th in one load are ignored.
- R12: Bytes written to the key addresses in a plain load are stored like any other byte, at index 5555h[ARR_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_addr | input | ADDR_W | Full write address, compared for keys |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ARR_W | Array read index |
| rd_data | output | 8 | Read result, valid the cycle after rd_en |
| busy | output | 1 | Write cycle in progress |

## Verification
Two functions can meet in the same cycle: a status read and an ignored write strobe during a write cycle. The bench drives rd_en and wr_en together while busy is 1. It expects the status byte to continue the bit-6 alternation as though the read were alone. Afterwards it confirms that the byte at the written index is unchanged and that no new write cycle starts within the load window.

// File: rtl/eeprom_guard.sv
module eeprom_guard #(
  parameter int ADDR_W   = 15,
  parameter int ARR_W    = 4,
  parameter int PAGE_SZ  = 8,
  parameter int PAGE_WIN = 8,
  parameter int TWC      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ARR_W-1:0]  rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);
  localparam int DEPTH = 1 << ARR_W;
  localparam int IDX_W = $clog2(PAGE_SZ);
  localparam int CNT_W = $clog2(PAGE_SZ + 1);
  localparam int GAP_W = $clog2(PAGE_WIN + 1);
  localparam int WC_W  = $clog2(TWC + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(PAGE_SZ);
  localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(PAGE_WIN - 1);
  localparam logic [WC_W-1:0]   WC_LAST  = WC_W'(TWC - 1);
  localparam logic [ADDR_W-1:0] KEY_HI   = ADDR_W'(15'h5555);
  localparam logic [ADDR_W-1:0] KEY_LO   = ADDR_W'(15'h2AAA);

  typedef enum logic [1:0] {LD_PLAIN, LD_ARM, LD_UNARM} lead_t;

  logic [7:0]       mem  [DEPTH];
  logic [ARR_W-1:0] pg_a [PAGE_SZ];
  logic [7:0]       pg_d [PAGE_SZ];
  logic [CNT_W-1:0] pg_n;
  logic             loading;
  logic [GAP_W-1:0] gap;
  logic [WC_W-1:0]  wc;
  logic [2:0]       step;
  logic             step_dead;
  lead_t            lead;
  logic             sdp, arm_pend, unarm_pend;
  logic             load_d7, poll_d7, tgl;
  logic [7:0]       rd_q;
  logic [2:0]       skip;
  logic             step_ok;

  wire hi      = (wr_addr == KEY_HI);
  wire lo      = (wr_addr == KEY_LO);
  wire take    = wr_en && !busy && (pg_n < CNT_FULL);
  wire close   = loading && !take && (gap == GAP_LAST);
  wire cyc_end = busy && (wc == WC_LAST);
  wire allow   = (lead != LD_PLAIN) || !sdp;

  assign rd_data = rd_q;

  always_comb begin
    case (step)
      3'd0:    step_ok = hi && wr_data == 8'hAA;
      3'd1:    step_ok = lo && wr_data == 8'h55;
      3'd2:    step_ok = hi && (wr_data == 8'hA0 || wr_data == 8'h80);
      3'd3:    step_ok = hi && wr_data == 8'hAA;
      3'd4:    step_ok = lo && wr_data == 8'h55;
      3'd5:    step_ok = hi && wr_data == 8'h20;
      default: step_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (lead)
      LD_ARM:   skip = 3'd3;
      LD_UNARM: skip = 3'd6;
      default:  skip = 3'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_n       <= '0;
      loading    <= 1'b0;
      gap        <= '0;
      wc         <= '0;
      busy       <= 1'b0;
      step       <= '0;
      step_dead  <= 1'b0;
      lead       <= LD_PLAIN;
      arm_pend   <= 1'b0;
      unarm_pend <= 1'b0;
      load_d7    <= 1'b0;
      poll_d7    <= 1'b0;
      tgl        <= 1'b0;
      rd_q       <= '0;
    end else begin
      if (take) begin
        pg_n    <= pg_n + 1'b1;
        loading <= 1'b1;
        gap     <= '0;
        load_d7 <= wr_data[7];
        if (!step_dead) begin
          if (!step_ok) step_dead <= 1'b1;
          else if (step == 3'd2 && wr_data == 8'hA0) begin
            lead      <= LD_ARM;
            step_dead <= 1'b1;
          end else if (step == 3'd5) begin
            lead      <= LD_UNARM;
            step_dead <= 1'b1;
          end else step <= step + 1'b1;
        end
      end else if (close) begin
        loading    <= 1'b0;
        busy       <= 1'b1;
        wc         <= '0;
        tgl        <= 1'b0;
        pg_n       <= '0;
        step       <= '0;
        step_dead  <= 1'b0;
        lead       <= LD_PLAIN;
        arm_pend   <= (lead == LD_ARM);
        unarm_pend <= (lead == LD_UNARM);
        poll_d7    <= load_d7;
      end else if (loading) begin
        gap <= gap + 1'b1;
      end
      if (busy) begin
        wc <= wc + 1'b1;
        if (cyc_end) busy <= 1'b0;
      end
      if (rd_en) begin
        if (busy) begin
          rd_q <= {~poll_d7, ~tgl, 6'b0};
          tgl  <= ~tgl;
        end else begin
          rd_q <= mem[rd_addr];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      pg_a[pg_n[IDX_W-1:0]] <= wr_addr[ARR_W-1:0];
      pg_d[pg_n[IDX_W-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (close && allow) begin
      for (int i = 0; i < PAGE_SZ; i++) begin
        if (i >= 32'(skip) && i < 32'(pg_n)) mem[pg_a[i]] <= pg_d[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cyc_end) begin
      if (arm_pend) sdp <= 1'b1;
      else if (unarm_pend) sdp <= 1'b0;
    end
  end

  logic [WC_W:0] bl;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) bl <= '0;
    else bl <= bl + 1'b1;
  end

  a_r2_start_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(loading));
  a_r2_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bl == (WC_W+1)'(TWC));
  a_r2_no_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !loading);
  a_r4_poll_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && $past(rd_en && busy)) |=> rd_q[6] != $past(rd_q[6]));
  a_r4_poll_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> rd_q[5:0] == 6'b0);
  a_r9_flag_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdp) |-> $fell(busy));
endmodule

// File: tb/eeprom_guard_test.sv
`timescale 1ns/1ps
module eeprom_guard_test;
  localparam int PW = 8;
  localparam int TW = 20;
  localparam logic [1:0] OW = 2'd0, OC = 2'd1, ORD = 2'd2;
  localparam int NV = 63;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  eeprom_guard #(.ADDR_W(15), .ARR_W(4), .PAGE_SZ(8), .PAGE_WIN(PW), .TWC(TW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

  // {op, requirement, address, data or expected}
  localparam logic [28:0] VEC [NV] = '{
    {OW, 4'd3, 15'h0003, 8'h11},  // R3 plain load
    {OW, 4'd3, 15'h0004, 8'h22},
    {OW, 4'd3, 15'h0009, 8'h01},
    {OW, 4'd3, 15'h000D, 8'hD0},
    {OC, 4'd3, 15'h0000, 8'h00},
    {ORD, 4'd3, 15'h0003, 8'h11},
    {ORD, 4'd3, 15'h0004, 8'h22},
    {ORD, 4'd3, 15'h0009, 8'h01},
    {OW, 4'd3, 15'h0007, 8'h33},  // R3 later byte wins
    {OW, 4'd3, 15'h0007, 8'h44},
    {OC, 4'd3, 15'h0000, 8'h00},
    {ORD, 4'd3, 15'h0007, 8'h44},
    {OW, 4'd12, 15'h5555, 8'h12}, // R12 key address as data
    {OC, 4'd12, 15'h0000, 8'h00},
    {ORD, 4'd12, 15'h0005, 8'h12},
    {OW, 4'd5, 15'h5555, 8'hAA},  // R5 arm plus data
    {OW, 4'd5, 15'h2AAA, 8'h55},
    {OW, 4'd5, 15'h5555, 8'hA0},
    {OW, 4'd5, 15'h0001, 8'h5A},
    {OC, 4'd5, 15'h0000, 8'h00},
    {ORD, 4'd5, 15'h0001, 8'h5A},
    {ORD, 4'd5, 15'h0005, 8'h12},
    {OW, 4'd7, 15'h0001, 8'h77},  // R7 blocked
    {OC, 4'd7, 15'h0000, 8'h00},
    {ORD, 4'd7, 15'h0001, 8'h5A},
    {OW, 4'd6, 15'h5555, 8'hAA},  // R6 keyed write
    {OW, 4'd6, 15'h2AAA, 8'h55},
    {OW, 4'd6, 15'h5555, 8'hA0},
    {OW, 4'd6, 15'h0002, 8'h66},
    {OC, 4'd6, 15'h0000, 8'h00},
    {ORD, 4'd6, 15'h0002, 8'h66},
    {OW, 4'd10, 15'h5555, 8'hAA}, // R10 broken key, protected
    {OW, 4'd10, 15'h2AAA, 8'h55},
    {OW, 4'd10, 15'h0002, 8'h99},
    {OC, 4'd10, 15'h0000, 8'h00},
    {ORD, 4'd10, 15'h0002, 8'h66},
    {OW, 4'd8, 15'h5555, 8'hAA},  // R8 disarm
    {OW, 4'd8, 15'h2AAA, 8'h55},
    {OW, 4'd8, 15'h5555, 8'h80},
    {OW, 4'd8, 15'h5555, 8'hAA},
    {OW, 4'd8, 15'h2AAA, 8'h55},
    {OW, 4'd8, 15'h5555, 8'h20},
    {OC, 4'd8, 15'h0000, 8'h00},
    {ORD, 4'd8, 15'h0005, 8'h12},
    {OW, 4'd8, 15'h0002, 8'hC3},
    {OC, 4'd8, 15'h0000, 8'h00},
    {ORD, 4'd8, 15'h0002, 8'hC3},
    {OW, 4'd10, 15'h5555, 8'hAA}, // R10 broken key, unprotected
    {OW, 4'd10, 15'h2AAA, 8'h55},
    {OW, 4'd10, 15'h0006, 8'h0F},
    {OC, 4'd10, 15'h0000, 8'h00},
    {ORD, 4'd10, 15'h0005, 8'hAA},
    {ORD, 4'd10, 15'h000A, 8'h55},
    {ORD, 4'd10, 15'h0006, 8'h0F},
    {OW, 4'd10, 15'h5555, 8'hAA}, // R10 key cut by load window
    {OC, 4'd10, 15'h0000, 8'h00},
    {OW, 4'd10, 15'h2AAA, 8'h55},
    {OW, 4'd10, 15'h5555, 8'hA0},
    {OC, 4'd10, 15'h0000, 8'h00},
    {OW, 4'd10, 15'h000B, 8'h3C},
    {OC, 4'd10, 15'h0000, 8'h00},
    {ORD, 4'd10, 15'h000B, 8'h3C},
    {ORD, 4'd10, 15'h0005, 8'hA0}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [14:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [14:0] a, logic [7:0] exp, string req);
    rd_en = 1'b1; rd_addr = a[3:0];
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rd_data, exp);
  endtask

  task automatic wait_busy(string req);
    int n = 0;
    while (!busy && n < PW + 4) begin @(negedge clk); n++; end
    check({req, " cycle start"}, busy, 1);
  endtask

  task automatic settle(string req);
    int n = 0;
    wait_busy(req);
    while (busy && n < TW + 4) begin @(negedge clk); n++; end
    check({req, " cycle end"}, busy, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic arm();
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
  endtask

  task automatic disarm();
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    logic [28:0] v;
    string tag;
    int n, m;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 rd_data in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 rd_data after reset", rd_data, 8'h00);
    disarm();
    settle("R8 initial disarm");

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      tag = $sformatf("R%0d", v[26:23]);
      case (v[28:27])
        OW:  wr(v[22:8], v[7:0]);
        OC:  settle(tag);
        default: rd(v[22:8], v[7:0], $sformatf("%s read %0h", tag, v[22:8]));
      endcase
    end

    // R2 timing, R4 polling, write during status read
    wr(15'h0008, 8'h85);
    n = 0;
    while (!busy && n < 40) begin @(negedge clk); n++; end
    check("R2 load window", n, PW);
    m = 0;
    rd(0, 8'h40, "R4 first poll"); m++;
    rd(0, 8'h00, "R4 second poll"); m++;
    rd_en = 1'b1; rd_addr = 4'h0; wr_en = 1'b1; wr_addr = 15'h0009; wr_data = 8'hEE;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; m++;
    check("R4 third poll with write", rd_data, 8'h40);
    while (busy && m < 60) begin @(negedge clk); m++; end
    check("R2 cycle length", m, TW);
    rd(8, 8'h85, "R4 data after cycle");
    repeat (PW + 4) @(negedge clk);
    check("R2 busy write starts no load", busy, 0);
    rd(9, 8'h01, "R2 busy write ignored");

    // R11 page overflow
    for (int i = 1; i <= 9; i++) wr(15'h000C, 8'(i));
    settle("R11");
    rd(12, 8'h08, "R11 ninth write dropped");

    // R4 bit 7 with low last byte
    wr(15'h000E, 8'h05);
    wait_busy("R4");
    rd(0, 8'hC0, "R4 poll bit7");
    n = 0;
    while (busy && n < TW + 4) begin @(negedge clk); n++; end
    rd(14, 8'h05, "R4 stored after cycle");

    // R9 persistence, R1 mid-cycle reset
    arm();
    settle("R5 arm only");
    wr(15'h000D, 8'h5D);
    wait_busy("R7 blocked write");
    do_reset();
    check("R1 reset ends cycle", busy, 0);
    wr(15'h000D, 8'h5D);
    settle("R7 after reset");
    rd(13, 8'hD0, "R9 protection survives reset");
    disarm();
    settle("R8 disarm");
    wr(15'h000D, 8'h5D);
    settle("R8 plain");
    rd(13, 8'h5D, "R8 plain write after disarm");

    finish_run();
  end
endmodule